// File: doc/BRIEF.md
# Page-Offset-Indexed Read Cache with Parallel Translation

This block is a direct-mapped read cache that sits behind a virtual address. Its line index and byte select come only from the low twelve bits of the address, which translation never changes. The line array read can therefore start at the moment a request is accepted. A fully associative table of eight page translations is searched on the upper twenty bits at the same time. In the next cycle the tag stored in the line is compared with the physical page number the table returns, and that decides hit or miss.

Requests arrive on a valid/ready channel. A translation that hits and permits reading then follows one of two paths:

- On a cache hit, the word is answered straight away.
- On a cache miss, a word read goes to memory at the translated address. The returned word fills the line and is also answered.

A request whose page has no translation is answered with a translation-miss code and the virtual page number, so that an outside walker can install the entry through the fill port. A translation that forbids reading is answered with a protection-fault code and never reaches memory. One request is in flight at a time. `req_ready` is low from acceptance until the answer has been taken. The answer and the memory read request each hold all their fields until their ready input is seen high at a clock edge.

Top module: `vicache`

## Requirements
- R1: After reset, `req_ready` is 1, while `resp_valid` and `mem_req_valid` are 0. All translations and all cache lines are invalid, so the first request is answered as a translation miss.
- R2: A request whose page number matches no valid translation is answered with `resp_kind` = 1 and `resp_vpn` equal to `req_vaddr[31:12]`, and no memory read is issued.
- R3: A translation whose rights bit 0 (read permitted) is 0 yields `resp_kind` = 2 and issues no memory read. The entry's rights and dirty bit are still reported.
- R4: On a translation hit with read permission and a cache miss, one memory read is issued. Its address is {physical page, `req_vaddr[11:2]`, 2'b00}.
- R5: The word returned on `mem_rsp_word` is answered with `resp_kind` = 0. It is also written into the line at index `req_vaddr[11:2]` with the physical page as tag, and that line becomes valid. A later request to the same physical line is then answered from the line with no memory read.
- R6: A valid line hits only when its stored tag equals the physical page of the current translation. The same index reached through a page that maps to another physical page misses.
- R7: `resp_byte` is the byte of `resp_word` selected by `req_vaddr[1:0]`, where 0 selects bits 7:0.
- R8: Fills go to the eight entries in round-robin order starting at entry 0. The ninth fill after reset replaces the first one installed.
- R9: On every translation hit, the entry's referenced bit is set. `resp_fresh` is 1 when that bit was clear before the access, so it is 1 only on the first translated access after the entry was filled. `resp_rights` and `resp_dirty` carry the entry's stored bits.
- R10: While `resp_valid` is high and `resp_ready` is low, all response fields stay unchanged. `req_ready` stays low from acceptance until the response handshake.
- R11: While `mem_req_valid` is high and `mem_req_ready` is low, the request and its address stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 32 | Virtual byte address |
| resp_valid | output | 1 | Answer present |
| resp_ready | input | 1 | Answer taken |
| resp_kind | output | 2 | 0 data, 1 translation miss, 2 protection fault |
| resp_word | output | 32 | Line word (data answers) |
| resp_byte | output | 8 | Byte picked by address bits 1:0 |
| resp_vpn | output | 20 | Virtual page number of the request |
| resp_fresh | output | 1 | Referenced bit was clear before this access |
| resp_rights | output | 2 | Access rights of the matching entry |
| resp_dirty | output | 1 | Dirty bit of the matching entry |
| mem_req_valid | output | 1 | Memory word read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Physical word address |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_word | input | 32 | Returned word |
| tlb_fill_en | input | 1 | Install one translation |
| tlb_fill_vpn | input | 20 | Virtual page to install |
| tlb_fill_ppn | input | 20 | Physical page to install |
| tlb_fill_rights | input | 2 | Rights, bit 0 read permitted |
| tlb_fill_dirty | input | 1 | Dirty bit to install |

## Verification
The assertions assume three things about the inputs:

- No virtual page is installed in two entries at once.
- `mem_rsp_valid` is raised only after the memory read handshake.
- Fills happen only while the block is idle.

The stimulus meets these conditions. It picks each new page from a pool and skips any page that is still resident in its model of the table. It answers memory reads only after accepting them, and it fills only between requests. Delays on all three ready and valid inputs are random, so back-pressure is applied at every stage.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int ADDR_W = 32;
  localparam int OFS_W  = 12;
  localparam int PAGE_W = ADDR_W - OFS_W;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    RK_DATA   = 2'd0,
    RK_XMISS  = 2'd1,
    RK_PFAULT = 2'd2
  } rsp_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_MREQ,
    ST_MWAIT,
    ST_RESP
  } ctl_state_e;
endpackage

// File: rtl/vic_line_store.sv
module vic_line_store #(
  parameter int LINES  = 1024,
  parameter int TAG_W  = 20,
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rd_en,
  input  logic [$clog2(LINES)-1:0] rd_idx,
  input  logic                     wr_en,
  input  logic [$clog2(LINES)-1:0] wr_idx,
  input  logic [TAG_W-1:0]         wr_tag,
  input  logic [DATA_W-1:0]        wr_data,
  output logic                     rd_vld,
  output logic [TAG_W-1:0]         rd_tag,
  output logic [DATA_W-1:0]        rd_data
);
  localparam int ROW_W = TAG_W + DATA_W;

  logic [ROW_W-1:0] row_q [LINES];
  logic [ROW_W-1:0] out_q;
  logic [LINES-1:0] vld_q;
  logic             out_vld_q;

  always_ff @(posedge clk) begin
    if (wr_en) row_q[wr_idx] <= {wr_tag, wr_data};
    if (rd_en) out_q <= row_q[rd_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q     <= '0;
      out_vld_q <= 1'b0;
    end else begin
      if (wr_en) vld_q[wr_idx] <= 1'b1;
      if (rd_en) out_vld_q <= vld_q[rd_idx];
    end
  end

  assign rd_vld  = out_vld_q;
  assign rd_tag  = out_q[ROW_W-1:DATA_W];
  assign rd_data = out_q[DATA_W-1:0];

  AST_FILL_MARKS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> vld_q[$past(wr_idx)]); // R5
endmodule

// File: rtl/vic_tlb.sv
module vic_tlb #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic [1:0]       fill_rights,
  input  logic             fill_dirty,
  input  logic [VPN_W-1:0] look_vpn,
  input  logic             touch,
  output logic             hit,
  output logic [PPN_W-1:0] hit_ppn,
  output logic [1:0]       hit_rights,
  output logic             hit_ref,
  output logic             hit_dirty
);
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] e_vld, e_ref, e_dirty, match;
  logic [VPN_W-1:0]   e_vpn    [ENTRIES];
  logic [PPN_W-1:0]   e_ppn    [ENTRIES];
  logic [1:0]         e_rights [ENTRIES];
  logic [PTR_W-1:0]   ptr_q, sel;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = e_vld[g] && (e_vpn[g] == look_vpn);
  end

  always_comb begin
    sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) sel = PTR_W'(i);
    end
  end

  assign hit        = |match;
  assign hit_ppn    = e_ppn[sel];
  assign hit_rights = e_rights[sel];
  assign hit_ref    = e_ref[sel];
  assign hit_dirty  = e_dirty[sel];

  always_ff @(posedge clk) begin
    if (fill_en) begin
      e_vpn[ptr_q]    <= fill_vpn;
      e_ppn[ptr_q]    <= fill_ppn;
      e_rights[ptr_q] <= fill_rights;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_vld   <= '0;
      e_ref   <= '0;
      e_dirty <= '0;
      ptr_q   <= '0;
    end else begin
      if (touch && hit) e_ref[sel] <= 1'b1;
      if (fill_en) begin
        e_vld[ptr_q]   <= 1'b1;
        e_ref[ptr_q]   <= 1'b0;
        e_dirty[ptr_q] <= fill_dirty;
        ptr_q          <= (ptr_q == PTR_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
      end
    end
  end

  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match)); // R8
  AST_REF_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (touch && hit && !fill_en) |=> e_ref[$past(sel)]); // R9
endmodule

// File: rtl/vicache.sv
module vicache #(
  parameter int LINES       = 1024,
  parameter int TLB_ENTRIES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_vaddr,
  output logic        resp_valid,
  input  logic        resp_ready,
  output logic [1:0]  resp_kind,
  output logic [31:0] resp_word,
  output logic [7:0]  resp_byte,
  output logic [19:0] resp_vpn,
  output logic        resp_fresh,
  output logic [1:0]  resp_rights,
  output logic        resp_dirty,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [31:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_word,
  input  logic        tlb_fill_en,
  input  logic [19:0] tlb_fill_vpn,
  input  logic [19:0] tlb_fill_ppn,
  input  logic [1:0]  tlb_fill_rights,
  input  logic        tlb_fill_dirty
);
  import vic_pkg::*;

  localparam int IDX_W = $clog2(LINES);
  localparam int SEL_W = OFS_W - IDX_W;

  ctl_state_e        st_q;
  logic [ADDR_W-1:0] va_q;
  logic [PAGE_W-1:0] ppn_q;
  rsp_kind_e         kind_q;
  logic [WORD_W-1:0] word_q;
  logic              fresh_q, dirty_q;
  logic [1:0]        rights_q;

  logic              acc, t_hit, t_ref, t_dirty, l_vld;
  logic [PAGE_W-1:0] t_ppn, l_tag;
  logic [1:0]        t_rights;
  logic [WORD_W-1:0] l_data;
  logic              fill_line;

  assign req_ready = (st_q == ST_IDLE);
  assign acc       = req_valid && req_ready;
  assign fill_line = (st_q == ST_MWAIT) && mem_rsp_valid;

  vic_tlb #(.ENTRIES(TLB_ENTRIES), .VPN_W(PAGE_W), .PPN_W(PAGE_W)) u_tlb (
    .clk(clk), .rst_n(rst_n),
    .fill_en(tlb_fill_en), .fill_vpn(tlb_fill_vpn), .fill_ppn(tlb_fill_ppn),
    .fill_rights(tlb_fill_rights), .fill_dirty(tlb_fill_dirty),
    .look_vpn(va_q[ADDR_W-1:OFS_W]), .touch(st_q == ST_LOOK),
    .hit(t_hit), .hit_ppn(t_ppn), .hit_rights(t_rights),
    .hit_ref(t_ref), .hit_dirty(t_dirty)
  );

  vic_line_store #(.LINES(LINES), .TAG_W(PAGE_W), .DATA_W(WORD_W)) u_lines (
    .clk(clk), .rst_n(rst_n),
    .rd_en(acc), .rd_idx(req_vaddr[OFS_W-1:SEL_W]),
    .wr_en(fill_line), .wr_idx(va_q[OFS_W-1:SEL_W]),
    .wr_tag(ppn_q), .wr_data(mem_rsp_word),
    .rd_vld(l_vld), .rd_tag(l_tag), .rd_data(l_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      va_q     <= '0;
      ppn_q    <= '0;
      kind_q   <= RK_DATA;
      word_q   <= '0;
      fresh_q  <= 1'b0;
      dirty_q  <= 1'b0;
      rights_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (acc) begin
          va_q <= req_vaddr;
          st_q <= ST_LOOK;
        end
        ST_LOOK: begin
          ppn_q    <= t_ppn;
          fresh_q  <= t_hit && !t_ref;
          dirty_q  <= t_hit && t_dirty;
          rights_q <= t_hit ? t_rights : 2'b00;
          word_q   <= '0;
          if (!t_hit) begin
            kind_q <= RK_XMISS;
            st_q   <= ST_RESP;
          end else if (!t_rights[0]) begin
            kind_q <= RK_PFAULT;
            st_q   <= ST_RESP;
          end else if (l_vld && (l_tag == t_ppn)) begin
            kind_q <= RK_DATA;
            word_q <= l_data;
            st_q   <= ST_RESP;
          end else begin
            st_q <= ST_MREQ;
          end
        end
        ST_MREQ: if (mem_req_ready) st_q <= ST_MWAIT;
        ST_MWAIT: if (mem_rsp_valid) begin
          kind_q <= RK_DATA;
          word_q <= mem_rsp_word;
          st_q   <= ST_RESP;
        end
        ST_RESP: if (resp_ready) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign resp_valid    = (st_q == ST_RESP);
  assign resp_kind     = kind_q;
  assign resp_word     = word_q;
  assign resp_byte     = word_q[{va_q[1:0], 3'b000} +: 8];
  assign resp_vpn      = va_q[ADDR_W-1:OFS_W];
  assign resp_fresh    = fresh_q;
  assign resp_rights   = rights_q;
  assign resp_dirty    = dirty_q;
  assign mem_req_valid = (st_q == ST_MREQ);
  assign mem_req_addr  = {ppn_q, va_q[OFS_W-1:SEL_W], {SEL_W{1'b0}}};

  AST_MISS_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LOOK && !t_hit) |=> !mem_req_valid); // R2
  AST_FAULT_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LOOK && t_hit && !t_rights[0]) |=> !mem_req_valid); // R3
  AST_RESP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=> resp_valid && $stable(resp_word) && $stable(resp_kind)); // R10
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid || mem_req_valid) |-> !req_ready); // R10
  AST_MREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> mem_req_valid && $stable(mem_req_addr)); // R11
endmodule

// File: tb/test_vicache.sv
`timescale 1ns/1ps
module test_vicache;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        req_valid = 0, resp_ready = 0, mem_req_ready = 0, mem_rsp_valid = 0;
  logic [31:0] req_vaddr = 0, mem_rsp_word = 0;
  logic        tlb_fill_en = 0, tlb_fill_dirty = 0;
  logic [19:0] tlb_fill_vpn = 0, tlb_fill_ppn = 0;
  logic [1:0]  tlb_fill_rights = 0;
  logic        req_ready, resp_valid, resp_fresh, resp_dirty, mem_req_valid;
  logic [1:0]  resp_kind, resp_rights;
  logic [31:0] resp_word, mem_req_addr;
  logic [7:0]  resp_byte;
  logic [19:0] resp_vpn;

  vicache i_vicache (.*);

  int checks = 0, fails = 0;

  // bench model of the table and the line tags
  logic [19:0] m_vpn [8];
  logic [19:0] m_ppn [8];
  logic [1:0]  m_rt  [8];
  logic        m_v [8], m_ref [8], m_dt [8];
  int          m_ptr = 0;
  logic        l_v [1024];
  logic [19:0] l_tag [1024];

  function automatic logic [31:0] memw(input logic [31:0] pa);
    return (pa ^ 32'hA5C3_0F1E) * 32'd2654435761;
  endfunction

  function automatic int m_find(input logic [19:0] vpn);
    for (int i = 0; i < 8; i++) if (m_v[i] && m_vpn[i] == vpn) return i;
    return -1;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [19:0] ppn, input logic [1:0] rt, input logic dt);
    @(negedge clk);
    tlb_fill_en = 1; tlb_fill_vpn = vpn; tlb_fill_ppn = ppn;
    tlb_fill_rights = rt; tlb_fill_dirty = dt;
    @(negedge clk);
    tlb_fill_en = 0;
    m_vpn[m_ptr] = vpn; m_ppn[m_ptr] = ppn; m_rt[m_ptr] = rt;
    m_dt[m_ptr] = dt; m_v[m_ptr] = 1; m_ref[m_ptr] = 0;
    m_ptr = (m_ptr + 1) % 8;
  endtask

  task automatic access(input logic [31:0] va, input string ktag);
    int e, d, cyc;
    bit done, saw_mem, exp_mem, chit;
    logic [1:0]  ek;
    logic [31:0] epa, ew, a0, w0;
    logic [9:0]  idx;
    idx = va[11:2];
    e = m_find(va[31:12]);
    exp_mem = 0; ew = 0; epa = 0; chit = 0;
    if (e < 0) ek = 2'd1;
    else if (!m_rt[e][0]) ek = 2'd2;
    else begin
      ek = 2'd0;
      epa = {m_ppn[e], idx, 2'b00};
      ew = memw(epa);
      chit = l_v[idx] && l_tag[idx] == m_ppn[e];
      exp_mem = !chit;
    end
    @(negedge clk);
    req_valid = 1; req_vaddr = va;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    chk(!req_ready, "R10 busy", {31'b0, req_ready}, 0);
    done = 0; saw_mem = 0; cyc = 0;
    while (!done && cyc < 100) begin
      if (mem_req_valid && !saw_mem) begin
        saw_mem = 1;
        chk(mem_req_addr == epa, "R4 addr", mem_req_addr, epa);
        a0 = mem_req_addr;
        d = $urandom % 3;
        repeat (d) begin
          @(negedge clk);
          chk(mem_req_valid && mem_req_addr == a0, "R11 hold", mem_req_addr, a0);
        end
        mem_req_ready = 1;
        @(negedge clk);
        mem_req_ready = 0;
        d = $urandom % 3;
        repeat (d) @(negedge clk);
        mem_rsp_valid = 1; mem_rsp_word = memw(a0);
        @(negedge clk);
        mem_rsp_valid = 0;
      end else if (resp_valid) begin
        w0 = resp_word;
        d = $urandom % 3;
        repeat (d) begin
          @(negedge clk);
          chk(resp_valid && resp_word == w0, "R10 hold", resp_word, w0);
        end
        chk(resp_kind == ek, ktag, {30'b0, resp_kind}, {30'b0, ek});
        chk(saw_mem == exp_mem, ek == 0 ? (chit ? "R5 no refetch" : "R4 fetch") : (ek == 1 ? "R2 no mem" : "R3 no mem"),
            {31'b0, saw_mem}, {31'b0, exp_mem});
        if (ek == 2'd1) chk(resp_vpn == va[31:12], "R2 vpn", {12'b0, resp_vpn}, {12'b0, va[31:12]});
        if (ek == 2'd0) begin
          chk(resp_word == ew, "R5 word", resp_word, ew);
          chk(resp_byte == ew[8*va[1:0] +: 8], "R7 byte", {24'b0, resp_byte}, {24'b0, ew[8*va[1:0] +: 8]});
        end
        if (e >= 0) begin
          chk(resp_fresh == !m_ref[e], "R9 fresh", {31'b0, resp_fresh}, {31'b0, !m_ref[e]});
          chk(resp_rights == m_rt[e] && resp_dirty == m_dt[e], "R9 status",
              {29'b0, resp_dirty, resp_rights}, {29'b0, m_dt[e], m_rt[e]});
          m_ref[e] = 1;
        end
        resp_ready = 1;
        @(negedge clk);
        resp_ready = 0;
        done = 1;
      end else begin
        @(negedge clk);
        cyc++;
      end
    end
    if (!done) chk(0, "R10 no answer", 0, 1);
    if (exp_mem) begin l_v[idx] = 1; l_tag[idx] = m_ppn[e]; end
  endtask

  initial begin
    #800000;
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin m_v[i] = 0; m_ref[i] = 0; end
    for (int i = 0; i < 1024; i++) l_v[i] = 0;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !resp_valid && !mem_req_valid, "R1 reset",
        {29'b0, req_ready, resp_valid, mem_req_valid}, 32'h4);
    access({20'h00100, 10'd5, 2'd0}, "R1 empty table");
    // directed: fill, miss, hit
    fill(20'h00100, 20'h80001, 2'b01, 1'b1);
    access({20'h00100, 10'd5, 2'd1}, "R4 first miss");
    access({20'h00100, 10'd5, 2'd3}, "R5 hit");
    // same index, other physical page: tag mismatch
    fill(20'h00101, 20'h80002, 2'b11, 1'b0);
    access({20'h00101, 10'd5, 2'd2}, "R6 tag mismatch");
    access({20'h00100, 10'd5, 2'd0}, "R6 line replaced");
    // read denied
    fill(20'h00102, 20'h80003, 2'b10, 1'b0);
    access({20'h00102, 10'd9, 2'd0}, "R3 fault");
    // eight more fills wrap the pointer and evict the first entries
    for (int i = 0; i < 8; i++) fill(20'h00200 + 20'(i), 20'h80010 + 20'(i), 2'b01, 1'b0);
    access({20'h00100, 10'd5, 2'd0}, "R8 evicted");
    access({20'h00207, 10'd7, 2'd0}, "R8 newest kept");
    // constrained random phase
    for (int n = 0; n < 400; n++) begin
      logic [19:0] v;
      if ($urandom % 100 < 15) begin
        for (int t = 0; t < 30; t++) begin
          v = 20'h00100 + 20'($urandom % 12);
          if (m_find(v) < 0) break;
        end
        if (m_find(v) < 0)
          fill(v, 20'h80000 + 20'($urandom % 6), ($urandom % 4 == 0) ? 2'b10 : 2'b01, 1'($urandom % 2));
      end else begin
        v = 20'h00100 + 20'($urandom % 12);
        access({v, 10'(($urandom % 12) * 37), 2'($urandom % 4)}, "R5 random kind");
      end
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule